// File: doc/BRIEF.md
# SAR Converter Conversion and Readout Sequencer

This block sits on the host side of a two-channel successive-approximation converter. It runs a full single-sample transaction from one request pulse. When the requested input differs from the one last programmed, it first sends a 16-bit channel-select word over SPI. It then drops the conversion-start line and waits for the converter's active-low end-of-conversion line, giving up after a programmable number of cycles. Next it raises conversion-start again. Finally it runs a second SPI frame that carries the fixed read command and captures the 16-bit sample returned in the same frame.

The converter keeps its input multiplexer setting between conversions. For that reason the sequencer remembers the last channel it programmed and skips the select frame when the same channel is asked for again. The serial clock comes from the system clock through a divider and idles high. Both the outgoing command bits and the incoming sample bits are taken on its falling edge. The result comes back as a one-cycle done pulse, together with the sample, the channel it belongs to and a timeout flag.

Top module: `sar_readout_seq`

## Requirements
- R1: After synchronous reset, chip select and conversion-start are high, the serial clock is high, busy and done are low.
- R2: A start pulse while idle makes busy high on the next cycle; a start pulse while busy is ignored and does not alter the channel being converted or add a second done pulse.
- R3: A channel-select frame carrying SEL_CMD_CH0 (channel 0) or SEL_CMD_CH1 (channel 1) is sent before conversion when the requested channel differs from the last one sent, and always on the first request after reset; otherwise no select frame is sent.
- R4: Conversion-start is driven low after any select frame and held low until end-of-conversion (active low, two-flop synchronised) is seen low or the timeout expires.
- R5: Conversion-start is back high before the read frame, and chip select is never low while conversion-start is low.
- R6: The read frame sends the word 0x0D00 and the 16 bits received in that frame become the reported result.
- R7: If end-of-conversion stays high, conversion-start stays low for exactly TIMEOUT_CYC cycles; the request then ends with timeout set, result zero, and no read frame.
- R8: Every frame holds chip select low for exactly 16 serial clock falling edges, sends MSB first, releases chip select between frames, and the serial clock is high whenever chip select is high.
- R9: Each serial clock level lasts SCLK_HALF system cycles; outgoing data changes only after a rising edge and incoming data is sampled at the falling edge.
- R10: Done is a single-cycle pulse; result, channel and timeout flag hold their values until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse for one sample |
| chan_i | input | 1 | Requested converter input (0 or 1) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Captured sample (zero on timeout) |
| result_chan_o | output | 1 | Channel of the reported sample |
| timeout_o | output | 1 | End-of-conversion did not arrive in time |
| spi_sclk_o | output | 1 | Serial clock, idles high |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data to converter |
| spi_miso_i | input | 1 | Serial data from converter |
| convst_n_o | output | 1 | Active-low conversion start |
| eoc_n_i | input | 1 | Active-low end-of-conversion |

## Verification
The bench drives a mix of requests. Some repeat a channel and some switch it, so a missing or surplus select frame shows up both in the converter model's frame count and in a sample drawn from the wrong input. End-of-conversion delays are swept from one cycle up to near the timeout window, and some requests get no response at all. This separates the normal path from the abort path, and the bench measures the exact length of the low conversion-start pulse on the abort path. A stray start pulse in the middle of a transaction shows that a request made while busy is ignored. Monitors on the serial lines count falling edges per frame and measure every half period.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int FRAME_BITS = 16;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam logic [FRAME_BITS-1:0] READ_CMD = 16'h0D00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_CONV,
        ST_RISE,
        ST_READ
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_END
    } spi_phase_t;

    typedef struct packed {
        logic [FRAME_BITS-1:0] data;
        logic                  chan;
        logic                  timed_out;
    } seq_result_t;

    // A select frame is needed when nothing was programmed yet or the input changes.
    function automatic logic need_select(input logic valid, input logic last, input logic req);
        return (!valid) || (last != req);
    endfunction

endpackage

// File: rtl/sar_spi_frame.sv
module sar_spi_frame
    import sar_seq_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go_i,
    input  logic [FRAME_BITS-1:0] word_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [FRAME_BITS-1:0] rx_o,
    output logic                  sclk_o,
    output logic                  cs_n_o,
    output logic                  mosi_o,
    input  logic                  miso_i
);

    localparam int HC_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(SCLK_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    spi_phase_t            phase;
    logic                  active;
    logic [HC_W-1:0]       hcnt;
    logic [BIT_W-1:0]      bcnt;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [FRAME_BITS-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_SETUP;
            active <= 1'b0;
            hcnt   <= '0;
            bcnt   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sclk_o <= 1'b1;
            cs_n_o <= 1'b1;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!active) begin
                if (go_i) begin
                    active <= 1'b1;
                    cs_n_o <= 1'b0;
                    tx_sh  <= word_i;
                    phase  <= PH_SETUP;
                    hcnt   <= '0;
                    bcnt   <= '0;
                end
            end else if (hcnt != HC_LAST) begin
                hcnt <= hcnt + 1'b1;
            end else begin
                hcnt <= '0;
                unique case (phase)
                    PH_SETUP, PH_HIGH: begin
                        // falling edge: converter takes mosi, host takes miso
                        sclk_o <= 1'b0;
                        rx_sh  <= {rx_sh[FRAME_BITS-2:0], miso_i};
                        phase  <= PH_LOW;
                    end
                    PH_LOW: begin
                        sclk_o <= 1'b1;
                        if (bcnt == BIT_LAST) begin
                            phase <= PH_END;
                        end else begin
                            tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                            bcnt  <= bcnt + 1'b1;
                            phase <= PH_HIGH;
                        end
                    end
                    PH_END: begin
                        cs_n_o <= 1'b1;
                        active <= 1'b0;
                        done_o <= 1'b1;
                    end
                    default: phase <= PH_SETUP;
                endcase
            end
        end
    end

    assign busy_o = active;
    assign rx_o   = rx_sh;
    assign mosi_o = tx_sh[FRAME_BITS-1];

    // R8: serial clock rests high outside a frame
    a_r8_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> sclk_o);

    // R9: falling edges happen only inside a frame
    a_r9_fall_in_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> !cs_n_o);

    // R9: outgoing data does not move on a falling edge
    a_r9_mosi_steady_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> $stable(mosi_o));

endmodule

// File: rtl/sar_wait_timer.sv
module sar_wait_timer #(
    parameter int LIMIT = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt == LAST);

endmodule

// File: rtl/sar_readout_seq.sv
module sar_readout_seq
    import sar_seq_pkg::*;
#(
    parameter int          SCLK_HALF   = 2,
    parameter int          TIMEOUT_CYC = 2_000_000,
    parameter logic [15:0] SEL_CMD_CH0 = 16'h2000,
    parameter logic [15:0] SEL_CMD_CH1 = 16'h2400
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        chan_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] result_o,
    output logic        result_chan_o,
    output logic        timeout_o,
    output logic        spi_sclk_o,
    output logic        spi_cs_n_o,
    output logic        spi_mosi_o,
    input  logic        spi_miso_i,
    output logic        convst_n_o,
    input  logic        eoc_n_i
);

    seq_state_t            state;
    seq_result_t           res_q;
    logic                  req_ch;
    logic                  last_ch;
    logic                  last_valid;
    logic                  eoc_meta;
    logic                  eoc_sync;
    logic                  spi_go;
    logic [FRAME_BITS-1:0] spi_word;
    logic                  spi_busy;
    logic                  spi_done;
    logic [FRAME_BITS-1:0] spi_rx;
    logic                  tmr_exp;
    logic [FRAME_BITS-1:0] sel_word;

    always_comb sel_word = chan_i ? SEL_CMD_CH1 : SEL_CMD_CH0;

    // end-of-conversion comes from another device: two-flop synchroniser
    always_ff @(posedge clk) begin
        if (rst) begin
            eoc_meta <= 1'b1;
            eoc_sync <= 1'b1;
        end else begin
            eoc_meta <= eoc_n_i;
            eoc_sync <= eoc_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            req_ch     <= 1'b0;
            last_ch    <= 1'b0;
            last_valid <= 1'b0;
            convst_n_o <= 1'b1;
            spi_go     <= 1'b0;
            spi_word   <= '0;
            done_o     <= 1'b0;
            res_q      <= '0;
        end else begin
            spi_go <= 1'b0;
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        req_ch <= chan_i;
                        if (need_select(last_valid, last_ch, chan_i)) begin
                            spi_go     <= 1'b1;
                            spi_word   <= sel_word;
                            last_ch    <= chan_i;
                            last_valid <= 1'b1;
                            state      <= ST_SEL;
                        end else begin
                            convst_n_o <= 1'b0;
                            state      <= ST_CONV;
                        end
                    end
                end
                ST_SEL: begin
                    if (spi_done) begin
                        convst_n_o <= 1'b0;
                        state      <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (!eoc_sync) begin
                        convst_n_o <= 1'b1;
                        state      <= ST_RISE;
                    end else if (tmr_exp) begin
                        convst_n_o <= 1'b1;
                        done_o     <= 1'b1;
                        res_q      <= '{data: '0, chan: req_ch, timed_out: 1'b1};
                        state      <= ST_IDLE;
                    end
                end
                ST_RISE: begin
                    spi_go   <= 1'b1;
                    spi_word <= READ_CMD;
                    state    <= ST_READ;
                end
                ST_READ: begin
                    if (spi_done) begin
                        done_o <= 1'b1;
                        res_q  <= '{data: spi_rx, chan: req_ch, timed_out: 1'b0};
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    sar_spi_frame #(.SCLK_HALF(SCLK_HALF)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .go_i   (spi_go),
        .word_i (spi_word),
        .busy_o (spi_busy),
        .done_o (spi_done),
        .rx_o   (spi_rx),
        .sclk_o (spi_sclk_o),
        .cs_n_o (spi_cs_n_o),
        .mosi_o (spi_mosi_o),
        .miso_i (spi_miso_i)
    );

    sar_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (state == ST_CONV),
        .expired_o (tmr_exp)
    );

    assign busy_o        = (state != ST_IDLE);
    assign result_o      = res_q.data;
    assign result_chan_o = res_q.chan;
    assign timeout_o     = res_q.timed_out;

    // R2: a request made while busy leaves the captured channel alone
    a_r2_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(req_ch));

    // R5: no SPI frame overlaps a low conversion-start
    a_r5_no_frame_in_conv: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n_o |-> convst_n_o);

    // R5: the read frame is only launched while the frame engine is free
    a_r5_go_when_free: assert property (@(posedge clk) disable iff (rst)
        spi_go |-> !spi_busy);

    // R7: timer expiry releases conversion-start and reports a timeout
    a_r7_timeout_report: assert property (@(posedge clk) disable iff (rst)
        (tmr_exp && eoc_sync) |=> (convst_n_o && done_o && timeout_o));

    // R10: done lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: tb/sar_readout_seq_bench.sv
`timescale 1ns/1ps
module sar_readout_seq_bench;

    localparam int          HALF = 2;
    localparam int          TO   = 60;
    localparam logic [15:0] C0   = 16'h2000;
    localparam logic [15:0] C1   = 16'h2400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic chan_i = 1'b0;
    logic busy_o, done_o, result_chan_o, timeout_o;
    logic [15:0] result_o;
    logic spi_sclk_o, spi_cs_n_o, spi_mosi_o, spi_miso_i, convst_n_o;
    logic eoc_n_i = 1'b1;

    always #2.5 clk = ~clk;

    sar_readout_seq #(
        .SCLK_HALF(HALF), .TIMEOUT_CYC(TO), .SEL_CMD_CH0(C0), .SEL_CMD_CH1(C1)
    ) u_sar_readout_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .result_chan_o(result_chan_o), .timeout_o(timeout_o),
        .spi_sclk_o(spi_sclk_o), .spi_cs_n_o(spi_cs_n_o), .spi_mosi_o(spi_mosi_o),
        .spi_miso_i(spi_miso_i), .convst_n_o(convst_n_o), .eoc_n_i(eoc_n_i)
    );

    int checks = 0;
    int fails  = 0;

    function automatic logic [15:0] sample_of(input logic ch, input int seq);
        return (ch ? 16'hB000 : 16'h4000) ^ 16'(seq * 1103 + 7);
    endfunction

    // ---------------- converter model ----------------
    int          eoc_delay = -1;
    int          conv_seq  = 0;
    logic        mux       = 1'b0;
    logic [15:0] conv_word = 16'h0000;
    bit          conv_on   = 0;
    int          dcnt      = 0;

    always @(posedge clk) begin
        if (convst_n_o !== 1'b0) begin
            conv_on = 0;
            eoc_n_i <= 1'b1;
        end else begin
            if (!conv_on) begin
                conv_on = 1;
                dcnt = 0;
            end else begin
                dcnt++;
            end
            if (eoc_delay >= 0 && dcnt == eoc_delay && eoc_n_i) begin
                eoc_n_i   <= 1'b0;
                conv_word <= sample_of(mux, conv_seq);
                conv_seq++;
            end
        end
    end

    // ---------------- SPI slave model ----------------
    bit          in_frame = 0;
    int          nbit = 0, falls = 0;
    logic [15:0] rxw = '0, txw = '0;
    int          sel_frames = 0, read_frames = 0, bad_frames = 0, edge_bad = 0;

    assign spi_miso_i = (in_frame && nbit < 16) ? txw[15 - nbit] : 1'b0;

    always @(negedge spi_cs_n_o or posedge spi_cs_n_o or negedge spi_sclk_o) begin
        if (spi_cs_n_o === 1'b1) begin
            if (in_frame) begin
                in_frame = 0;
                if (falls != 16) edge_bad++;
                if (rxw == 16'h0D00) read_frames++;
                else if (rxw == C0) begin mux = 1'b0; sel_frames++; end
                else if (rxw == C1) begin mux = 1'b1; sel_frames++; end
                else bad_frames++;
            end
        end else if (spi_cs_n_o === 1'b0 && !in_frame) begin
            in_frame = 1; nbit = 0; falls = 0; rxw = '0; txw = conv_word;
        end else if (spi_cs_n_o === 1'b0 && spi_sclk_o === 1'b0) begin
            rxw = {rxw[14:0], spi_mosi_o};
            falls++;
            nbit++;
        end
    end

    // ---------------- line monitors ----------------
    logic prev_sclk = 1'b1, prev_cs = 1'b1;
    int   hcnt = 0, hp_bad = 0, overlap = 0, idle_sclk_bad = 0;
    int   low_run = 0, last_low = 0, dones = 0;

    always @(posedge clk) begin
        if (!rst) begin
            if (spi_sclk_o !== prev_sclk || spi_cs_n_o !== prev_cs) begin
                if (spi_sclk_o !== prev_sclk && spi_cs_n_o === 1'b0 && hcnt != HALF) hp_bad++;
                hcnt = 1;
            end else begin
                hcnt++;
            end
            prev_sclk = spi_sclk_o;
            prev_cs   = spi_cs_n_o;
            if (spi_cs_n_o === 1'b0 && convst_n_o === 1'b0) overlap++;
            if (spi_cs_n_o === 1'b1 && spi_sclk_o !== 1'b1) idle_sclk_bad++;
            if (convst_n_o === 1'b0) low_run++;
            else if (low_run != 0) begin last_low = low_run; low_run = 0; end
            if (done_o === 1'b1) dones++;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // expected state of the block, kept from the requirements
    logic last_m  = 1'b0;
    bit   valid_m = 0;
    int   exp_seq = 0;

    task automatic do_req(input logic ch, input int dly, input bit stray);
        int   sel0, rd0, dn0;
        bit   exp_sel;
        bit   exp_to;
        logic [15:0] exp_val;
        exp_sel = !valid_m || (last_m != ch);
        exp_to  = (dly < 0);
        exp_val = exp_to ? 16'h0000 : sample_of(ch, exp_seq);
        sel0 = sel_frames; rd0 = read_frames; dn0 = dones;
        eoc_delay = dly;
        @(negedge clk); start_i = 1'b1; chan_i = ch;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
        if (stray) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1; chan_i = !ch;
            @(negedge clk); start_i = 1'b0;
        end
        while (done_o !== 1'b1) @(negedge clk);
        chk(result_o === exp_val, "R6 result", int'(result_o), int'(exp_val));
        chk(result_chan_o === ch, "R2 result channel", int'(result_chan_o), int'(ch));
        chk(timeout_o === exp_to, "R7 timeout flag", int'(timeout_o), int'(exp_to));
        @(negedge clk);
        chk(done_o === 1'b0, "R10 done single cycle", int'(done_o), 0);
        chk(result_o === exp_val, "R10 result held", int'(result_o), int'(exp_val));
        repeat (4) @(negedge clk);
        chk(sel_frames - sel0 == int'(exp_sel), "R3 select frames", sel_frames - sel0, int'(exp_sel));
        chk(read_frames - rd0 == (exp_to ? 0 : 1), "R6 R7 read frames", read_frames - rd0, exp_to ? 0 : 1);
        chk(dones - dn0 == 1, "R2 one done per request", dones - dn0, 1);
        if (exp_to) chk(last_low == TO, "R7 convst low length", last_low, TO);
        else chk(last_low < TO, "R4 convst released on eoc", last_low, TO);
        if (exp_sel) begin last_m = ch; valid_m = 1; end
        if (!exp_to) exp_seq++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n_o === 1'b1, "R1 cs high", int'(spi_cs_n_o), 1);
        chk(convst_n_o === 1'b1, "R1 convst high", int'(convst_n_o), 1);
        chk(spi_sclk_o === 1'b1, "R1 sclk high", int'(spi_sclk_o), 1);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1 busy/done low", int'({busy_o, done_o}), 0);

        do_req(1'b0, 3,  0);
        do_req(1'b0, 8,  0);
        do_req(1'b1, 1,  0);
        do_req(1'b1, 20, 0);
        do_req(1'b0, 45, 0);
        do_req(1'b1, 3,  0);
        do_req(1'b1, -1, 0);   // R7 no end-of-conversion
        do_req(1'b1, 5,  0);
        do_req(1'b0, -1, 0);   // R7 timeout right after a select
        do_req(1'b1, 8,  0);
        do_req(1'b0, 20, 1);   // R2 stray start while busy
        do_req(1'b0, 1,  1);

        chk(edge_bad == 0, "R8 sixteen falls per frame", edge_bad, 0);
        chk(bad_frames == 0, "R8 MSB-first command words", bad_frames, 0);
        chk(idle_sclk_bad == 0, "R8 sclk high while cs high", idle_sclk_bad, 0);
        chk(hp_bad == 0, "R9 half period length", hp_bad, 0);
        chk(overlap == 0, "R5 no frame while convst low", overlap, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule